// File: doc/BRIEF.md
# Bidirectional I/O Port with Peripheral Override

An eight-pin general-purpose I/O port for a small microcontroller. Software owns two latches over a simple register bus: a data latch that holds the values to drive and a direction latch that marks each pin as input or output. Each pin appears at the block edge as three separate signals: a drive value, a drive enable and a sampled input. The pad ring joins these into a tristate pin.

Each pin has its own select line that hands the pin to an on-chip peripheral. While a pin is selected, the peripheral supplies the drive value. The peripheral's enable line also replaces the direction bit, so the peripheral can force the pin to drive or force it to listen. Reading the direction register still returns the latch contents, so during an override the real direction can differ from the value software reads.

Incoming pin levels pass through a two-flop synchronizer. The synchronized value feeds both the port data read path and the per-pin peripheral input lines. Two pins also carry a level-mode flag that tells the pad ring to use SMBus thresholds instead of standard two-wire-bus thresholds.

Top module: `pio_port`

## Requirements
- R1: After reset the direction latch reads 0xFF (every pin an input), the data latch is 0x00, `pad_oe` is 0x00, `pad_out` is 0x00 and `pin_lvl_sel` is 0x00.
- R2: A cycle with `bus_we`=1 and `bus_addr`=0 stores `bus_wdata` in the data latch at that clock edge. A cycle with `bus_we`=0 changes neither latch.
- R3: For a pin whose `periph_sel` bit is 0, direction bit 0 sets `pad_oe`=1 and direction bit 1 sets `pad_oe`=0, and `pad_out` equals the data latch bit.
- R4: For a pin whose `periph_sel` bit is 1, `pad_out` equals that pin's `periph_dout` bit.
- R5: For a pin whose `periph_sel` bit is 1, `pad_oe` equals that pin's `periph_oe` bit, whatever the direction latch holds.
- R6: Reading address 1 returns the direction latch contents, including while a peripheral overrides the direction. A direction write made during an override updates the latch but does not change `pad_oe` on the overridden pins.
- R7: Reading address 0 returns `pad_in` as sampled through two flops. A change of `pad_in` shows up after exactly two rising clock edges, and it never shows the data latch.
- R8: `periph_din` carries the same synchronized value as the address-0 read.
- R9: A value written to the data latch while a pin is an input appears on `pad_out` with `pad_oe`=1 once that pin's direction bit is cleared.
- R10: `pin_lvl_sel` bits 3 and 4 equal `lvl_mode` while the corresponding `periph_sel` bit is 1, and are 0 otherwise. All other bits are always 0.
- R11: A cycle with `bus_we`=1 and `bus_addr`=1 stores `bus_wdata` in the direction latch at that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Single-cycle register write strobe |
| bus_addr | input | 1 | Register select: 0 data, 1 direction |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| periph_sel | input | 8 | Per-pin hand-over to the peripheral |
| periph_dout | input | 8 | Peripheral drive values |
| periph_oe | input | 8 | Peripheral drive enables (1 forces output, 0 forces input) |
| lvl_mode | input | 1 | 1 selects SMBus input thresholds on the level pins |
| pad_in | input | 8 | Raw pin levels from the pads |
| pad_out | output | 8 | Pin drive values |
| pad_oe | output | 8 | Pin drive enables |
| periph_din | output | 8 | Synchronized pin levels to the peripherals |
| pin_lvl_sel | output | 8 | Per-pin threshold mode to the pads |

## Verification
Two events can fall in the same cycle: a software write to the direction latch and an active peripheral override of the same pins. The bench writes a new direction value while every pin is selected and checks that `pad_oe` keeps following `periph_oe`. It then checks that the read-back shows the new latch value and that releasing the select applies that value at once. A second overlap is a latch write during an address-0 read. The bench checks that the read keeps returning synchronized pin levels and never the latch contents.

// File: rtl/pio_pkg.sv
package pio_pkg;

    typedef enum logic {
        REG_DATA = 1'b0,
        REG_DIR  = 1'b1
    } reg_sel_e;

endpackage

// File: rtl/pio_regs.sv
module pio_regs
    import pio_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  reg_sel_e         addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] data_q,
    output logic [WIDTH-1:0] dir_q
);

    localparam logic [WIDTH-1:0] DIR_RESET  = '1;
    localparam logic [WIDTH-1:0] DATA_RESET = '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= DATA_RESET;
            dir_q  <= DIR_RESET;
        end else if (we) begin
            unique case (addr)
                REG_DATA: data_q <= wdata;
                REG_DIR:  dir_q  <= wdata;
            endcase
        end
    end

    // R2: a data write lands at the strobe edge
    p_data_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == REG_DATA) |=> data_q == $past(wdata));

    // R11: a direction write lands at the strobe edge
    p_dir_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == REG_DIR) |=> dir_q == $past(wdata));

    // R2: no strobe, no change
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> ($stable(data_q) && $stable(dir_q)));

endmodule

// File: rtl/pio_sync.sv
module pio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] stg [STAGES];
    logic [STAGES-1:0] fill_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stg[s] <= '0;
            end
            fill_q <= '0;
        end else begin
            stg[0] <= async_in;
            for (int s = 1; s < STAGES; s++) begin
                stg[s] <= stg[s-1];
            end
            fill_q <= {fill_q[STAGES-2:0], 1'b1};
        end
    end

    assign sync_out = stg[LAST];

    // R7: once the chain is filled, the output is the input STAGES edges ago
    p_sync_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fill_q[LAST] |-> sync_out == $past(async_in, STAGES));

endmodule

// File: rtl/pio_pinmux.sv
module pio_pinmux #(
    parameter int               WIDTH    = 8,
    parameter logic [WIDTH-1:0] LVL_MASK = '0
) (
    input  logic [WIDTH-1:0] data_q,
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] sel,
    input  logic [WIDTH-1:0] pdout,
    input  logic [WIDTH-1:0] poe,
    input  logic             lvl_mode,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] lvl_sel
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        assign pad_out[i] = sel[i] ? pdout[i] : data_q[i];
        assign pad_oe[i]  = sel[i] ? poe[i]   : ~dir_q[i];
        if (LVL_MASK[i]) begin : g_lvl
            assign lvl_sel[i] = sel[i] & lvl_mode;
        end else begin : g_std
            assign lvl_sel[i] = 1'b0;
        end
    end

endmodule

// File: rtl/pio_port.sv
module pio_port
    import pio_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int LVL_PIN_A   = 3,
    parameter int LVL_PIN_B   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_we,
    input  logic             bus_addr,
    input  logic [WIDTH-1:0] bus_wdata,
    output logic [WIDTH-1:0] bus_rdata,
    input  logic [WIDTH-1:0] periph_sel,
    input  logic [WIDTH-1:0] periph_dout,
    input  logic [WIDTH-1:0] periph_oe,
    input  logic             lvl_mode,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] periph_din,
    output logic [WIDTH-1:0] pin_lvl_sel
);

    localparam logic [WIDTH-1:0] LVL_MASK =
        WIDTH'((64'd1 << LVL_PIN_A) | (64'd1 << LVL_PIN_B));

    reg_sel_e         addr_e;
    logic [WIDTH-1:0] data_q;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] pin_sync;

    assign addr_e = reg_sel_e'(bus_addr);

    pio_regs #(.WIDTH(WIDTH)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (bus_we),
        .addr   (addr_e),
        .wdata  (bus_wdata),
        .data_q (data_q),
        .dir_q  (dir_q)
    );

    pio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pin_sync)
    );

    pio_pinmux #(.WIDTH(WIDTH), .LVL_MASK(LVL_MASK)) u_mux (
        .data_q   (data_q),
        .dir_q    (dir_q),
        .sel      (periph_sel),
        .pdout    (periph_dout),
        .poe      (periph_oe),
        .lvl_mode (lvl_mode),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe),
        .lvl_sel  (pin_lvl_sel)
    );

    assign periph_din = pin_sync;

    always_comb begin
        unique case (addr_e)
            REG_DATA: bus_rdata = pin_sync;
            REG_DIR:  bus_rdata = dir_q;
        endcase
    end

    // R3: on pins kept by the port, the drive enable is the inverse of the direction latch
    p_oe_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe ^ ~dir_q) & ~periph_sel) == '0);

    // R5: on selected pins the peripheral's enable wins over the latch
    p_sel_oe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe ^ periph_oe) & periph_sel) == '0);

    // R10: only the two level pins may request SMBus thresholds
    always_comb begin
        if (rst_n) begin
            p_lvl_mask_r10: assert ((pin_lvl_sel & ~LVL_MASK) == '0);
        end
    end

endmodule

// File: tb/pio_port_bench.sv
module pio_port_bench;

    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_we = 1'b0;
    logic         bus_addr = 1'b0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic [W-1:0] periph_sel = '0;
    logic [W-1:0] periph_dout = '0;
    logic [W-1:0] periph_oe = '0;
    logic         lvl_mode = 1'b0;
    logic [W-1:0] pad_in = '0;
    logic [W-1:0] pad_out;
    logic [W-1:0] pad_oe;
    logic [W-1:0] periph_din;
    logic [W-1:0] pin_lvl_sel;

    int n_run = 0;
    int n_fail = 0;
    logic [W-1:0] exp_data = '0;
    logic [W-1:0] exp_dir = '1;
    logic [W-1:0] rd;
    logic [W-1:0] prev;

    always #(CLK_PERIOD/2) clk = ~clk;

    pio_port u_pio_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .periph_sel  (periph_sel),
        .periph_dout (periph_dout),
        .periph_oe   (periph_oe),
        .lvl_mode    (lvl_mode),
        .pad_in      (pad_in),
        .pad_out     (pad_out),
        .pad_oe      (pad_oe),
        .periph_din  (periph_din),
        .pin_lvl_sel (pin_lvl_sel)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] expv);
        n_run++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, act, expv);
        end
    endtask

    task automatic bus_write(input logic a, input logic [W-1:0] v);
        @(negedge clk);
        bus_we = 1'b1;
        bus_addr = a;
        bus_wdata = v;
        @(posedge clk);
        #1;
        bus_we = 1'b0;
        if (a) exp_dir = v;
        else   exp_data = v;
    endtask

    task automatic bus_read(input logic a, output logic [W-1:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    function automatic logic [W-1:0] exp_oe(input logic [W-1:0] s, input logic [W-1:0] o,
                                            input logic [W-1:0] d);
        return (s & o) | (~s & ~d);
    endfunction

    function automatic logic [W-1:0] exp_out(input logic [W-1:0] s, input logic [W-1:0] p,
                                             input logic [W-1:0] l);
        return (s & p) | (~s & l);
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1 pad_oe", pad_oe, 8'h00);
        check("R1 pad_out", pad_out, 8'h00);
        check("R1 lvl", pin_lvl_sel, 8'h00);
        bus_read(1'b1, rd); check("R1 dir", rd, 8'hFF);
        bus_read(1'b0, rd); check("R1 data read", rd, 8'h00);

        // R2 data write, then idle cycles with changing bus
        bus_write(1'b0, 8'hA5);
        check("R2 latch", pad_out, 8'hA5);
        @(negedge clk); bus_wdata = 8'h3C; bus_addr = 1'b0;
        @(negedge clk); bus_addr = 1'b1;
        @(negedge clk); #1;
        check("R2 no strobe data", pad_out, 8'hA5);
        bus_read(1'b1, rd); check("R2 no strobe dir", rd, 8'hFF);

        // R11 direction write
        bus_write(1'b1, 8'h0F);
        bus_read(1'b1, rd); check("R11 dir", rd, 8'h0F);
        check("R11 oe", pad_oe, 8'hF0);

        // R3 sweep of every direction value
        for (int k = 0; k < 256; k++) begin
            bus_write(1'b1, W'(k));
            bus_write(1'b0, W'(k) ^ 8'h5A);
            check("R3 oe", pad_oe, ~W'(k));
            check("R3 out", pad_out, W'(k) ^ 8'h5A);
        end

        // R4 R5 sweep of every select pattern
        bus_write(1'b1, 8'h33);
        bus_write(1'b0, 8'hC3);
        for (int s = 0; s < 256; s++) begin
            @(negedge clk);
            periph_sel = W'(s);
            periph_dout = W'(s * 37);
            periph_oe = W'(s) ^ 8'h96;
            #1;
            check("R4 out", pad_out, exp_out(periph_sel, periph_dout, exp_data));
            check("R5 oe", pad_oe, exp_oe(periph_sel, periph_oe, exp_dir));
        end

        // R6 direction write while every pin is overridden
        @(negedge clk);
        periph_sel = 8'hFF; periph_oe = 8'hFF;
        #1;
        bus_read(1'b1, rd); check("R6 dir during override", rd, 8'h33);
        bus_write(1'b1, 8'hF0);
        check("R6 oe held", pad_oe, 8'hFF);
        bus_read(1'b1, rd); check("R6 dir read", rd, 8'hF0);
        @(negedge clk); periph_sel = 8'h00; #1;
        check("R6 release", pad_oe, 8'h0F);

        // R7 R8 synchronizer latency over every pin value
        bus_write(1'b0, 8'h00);
        prev = '0;
        @(negedge clk); pad_in = '0;
        repeat (2) @(negedge clk);
        for (int v = 1; v < 256; v++) begin
            @(negedge clk);
            pad_in = W'(v);
            bus_read(1'b0, rd);
            check("R7 before edge", rd, prev);
            @(negedge clk); bus_read(1'b0, rd);
            check("R7 one edge", rd, prev);
            @(negedge clk); bus_read(1'b0, rd);
            check("R7 two edges", rd, W'(v));
            check("R8 periph_din", periph_din, W'(v));
            prev = W'(v);
        end
        // R7 a latch write during a data read does not show the latch
        bus_write(1'b0, 8'h81);
        bus_read(1'b0, rd); check("R7 not latch", rd, 8'hFF);

        // R9 data written while input, then direction cleared
        bus_write(1'b1, 8'hFF);
        bus_write(1'b0, 8'h6C);
        check("R9 still input", pad_oe, 8'h00);
        bus_write(1'b1, 8'h00);
        check("R9 oe", pad_oe, 8'hFF);
        check("R9 out", pad_out, 8'h6C);

        // R10 level-mode pins
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 256; s++) begin
                @(negedge clk);
                lvl_mode = m[0];
                periph_sel = W'(s);
                #1;
                check("R10 lvl", pin_lvl_sel, W'(s) & 8'h18 & {W{m[0]}});
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule